// File: doc/BRIEF.md
# Program Counter Range Profiler

This block observes the program counter of every retired instruction, presented with a valid strobe. It attributes each one to a set of code-address windows that the host configures, and keeps a hit counter for each window. The result is a per-region execution histogram, built without sampling and without instrumenting the software. A host side register port loads the window bounds, selects the attribution mode, starts or stops profiling and clears the results. A separate index-addressed read port returns any counter.

Three modes are available. Overlapping mode credits every window that contains the PC. Exclusive mode credits only the first window that contains it. Trace mode counts nothing and instead queues the raw PC sequence in a small buffer, which a consumer drains through a pop strobe. A sticky flag records any PC lost because the buffer was full.

Top module: `pc_range_prof`

## Requirements
- R1: After reset every counter reads 0, profiling is stopped, the mode is overlapping, the trace buffer is empty (`trace_valid` low) and `trace_ovf` is low.
- R2: A window holds a PC when lower <= PC < upper (unsigned), so the lower bound is inside the window and the upper bound is outside it. A window whose lower bound is not below its upper bound matches nothing. The lower bound of window i is written at `cfg_addr` 16+2i and the upper bound at 17+2i.
- R3: In overlapping mode (control bits [2:1] = 00) a valid PC taken while running adds one to the counter of every window that contains it, in the clock edge that samples it.
- R4: In exclusive mode (control bits [2:1] = 01) a valid PC adds one only to the lowest-numbered window that contains it. At most one counter changes per PC.
- R5: In trace mode (control bits [2:1] = 10) each valid PC taken while running is queued in arrival order, and no counter changes. `trace_pc` shows the oldest entry while `trace_valid` is high, and `trace_pop` removes it. In the counting modes nothing is queued.
- R6: The trace buffer holds 16 entries. A PC that arrives while the buffer is full is dropped, even if a pop happens in the same cycle, and it sets `trace_ovf`. The flag then stays high until a clear.
- R7: Control bit 0 = 1 starts profiling and 0 stops it. A PC presented while stopped changes no counter and queues nothing.
- R8: Counters saturate at their all-ones value and never wrap to zero.
- R9: Writing control (`cfg_addr` 0) with bit 3 = 1 zeroes all counters, empties the trace buffer and clears `trace_ovf` in that edge. A PC taken in the same edge is not counted. The run and mode bits of the same write take effect as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | Retired instruction strobe |
| pc | input | AW (32) | Program counter of the retired instruction |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NUM_RANGES)+2 (5) | Register address: 0 = control, 16+ = window bounds |
| cfg_wdata | input | AW (32) | Register write data |
| rd_idx | input | $clog2(NUM_RANGES) (3) | Counter select |
| rd_count | output | CNT_W (32) | Selected counter value |
| trace_valid | output | 1 | Trace buffer not empty |
| trace_pc | output | AW (32) | Oldest queued PC |
| trace_pop | input | 1 | Remove the oldest queued PC |
| trace_ovf | output | 1 | Sticky trace drop flag |

## Verification
The hardest situation to reach is a PC arriving at a full trace buffer in the same cycle as a pop. The bench fills all 16 entries, pushes one more to raise the overflow flag, and then drives a PC and a pop together. It then drains the buffer and checks that exactly the original entries after the popped head come out. Saturation is reached by building the bench with narrow 8-bit counters and feeding one window more PCs than the counter can hold. Window edges are probed with PCs exactly at each lower bound and each upper bound.

// File: rtl/prof_pkg.sv
package prof_pkg;
    typedef enum logic [1:0] {
        MODE_OVL   = 2'd0,
        MODE_EXCL  = 2'd1,
        MODE_TRACE = 2'd2
    } prof_mode_e;
endpackage

// File: rtl/range_match.sv
module range_match #(
    parameter int N  = 8,
    parameter int AW = 32
) (
    input  logic [N-1:0][AW-1:0] lo,
    input  logic [N-1:0][AW-1:0] hi,
    input  logic [AW-1:0]        pc,
    output logic [N-1:0]         hit
);
    for (genvar g = 0; g < N; g++) begin : g_win
        // half-open window [lo, hi)
        assign hit[g] = (pc >= lo[g]) && (pc < hi[g]);
    end
endmodule

// File: rtl/hit_select.sv
module hit_select
    import prof_pkg::*;
#(
    parameter int N = 8
) (
    input  prof_mode_e   mode,
    input  logic [N-1:0] hit,
    output logic [N-1:0] inc
);
    always_comb begin
        case (mode)
            MODE_OVL:  inc = hit;
            MODE_EXCL: inc = hit & (~hit + 1'b1); // isolate lowest set bit
            default:   inc = '0;
        endcase
    end
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
    parameter int AW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [AW-1:0]              din,
    input  logic                       pop,
    output logic                       valid,
    output logic [AW-1:0]              dout,
    output logic                       ovf,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [PW:0]              lvl;
        logic                     ovf;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  full_q, do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        full_q  = (s_q.lvl == (PW+1)'(DEPTH));
        do_push = push && !full_q;
        do_pop  = pop && (s_q.lvl != '0);
        if (clr) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.lvl = '0;
            s_d.ovf = 1'b0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = din;
                s_d.wr          = s_q.wr + 1'b1;
            end
            if (do_pop) begin
                s_d.rd = s_q.rd + 1'b1;
            end
            s_d.lvl = s_q.lvl + (PW+1)'(do_push) - (PW+1)'(do_pop);
            if (push && full_q) begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = (s_q.lvl != '0);
    assign dout  = s_q.mem[s_q.rd];
    assign ovf   = s_q.ovf;
    assign level = s_q.lvl;
endmodule

// File: rtl/pc_range_prof.sv
module pc_range_prof
    import prof_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int AW         = 32,
    parameter int CNT_W      = 32,
    parameter int TQ_DEPTH   = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pc_valid,
    input  logic [AW-1:0]                  pc,
    input  logic                           cfg_we,
    input  logic [$clog2(NUM_RANGES)+1:0]  cfg_addr,
    input  logic [AW-1:0]                  cfg_wdata,
    input  logic [$clog2(NUM_RANGES)-1:0]  rd_idx,
    output logic [CNT_W-1:0]               rd_count,
    output logic                           trace_valid,
    output logic [AW-1:0]                  trace_pc,
    input  logic                           trace_pop,
    output logic                           trace_ovf
);
    localparam int IW   = $clog2(NUM_RANGES);
    localparam int CA_W = IW + 2;
    localparam int LW   = $clog2(TQ_DEPTH) + 1;

    typedef struct packed {
        logic                                run;
        prof_mode_e                          mode;
        logic [NUM_RANGES-1:0][AW-1:0]       lo;
        logic [NUM_RANGES-1:0][AW-1:0]       hi;
        logic [NUM_RANGES-1:0][CNT_W-1:0]    cnt;
    } state_t;

    state_t                 s_d, s_q;
    logic                   clr_cmd;
    logic                   count_en;
    logic                   push;
    logic [NUM_RANGES-1:0]  hit;
    logic [NUM_RANGES-1:0]  inc;
    logic [LW-1:0]          fifo_level;
    logic [IW-1:0]          bound_idx;

    range_match #(.N(NUM_RANGES), .AW(AW)) u_match (
        .lo  (s_q.lo),
        .hi  (s_q.hi),
        .pc  (pc),
        .hit (hit)
    );

    hit_select #(.N(NUM_RANGES)) u_sel (
        .mode (s_q.mode),
        .hit  (hit),
        .inc  (inc)
    );

    assign bound_idx = cfg_addr[CA_W-2:1];
    assign count_en  = s_q.run && pc_valid && (s_q.mode != MODE_TRACE);
    assign push      = s_q.run && pc_valid && (s_q.mode == MODE_TRACE);

    always_comb begin
        s_d     = s_q;
        clr_cmd = 1'b0;
        if (cfg_we) begin
            if (cfg_addr == '0) begin
                s_d.run = cfg_wdata[0];
                case (cfg_wdata[2:1])
                    2'b01:   s_d.mode = MODE_EXCL;
                    2'b10:   s_d.mode = MODE_TRACE;
                    default: s_d.mode = MODE_OVL;
                endcase
                clr_cmd = cfg_wdata[3];
            end else if (cfg_addr[CA_W-1]) begin
                if (cfg_addr[0]) s_d.hi[bound_idx] = cfg_wdata;
                else             s_d.lo[bound_idx] = cfg_wdata;
            end
        end
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (clr_cmd) begin
                s_d.cnt[i] = '0;
            end else if (count_en && inc[i] && (s_q.cnt[i] != {CNT_W{1'b1}})) begin
                s_d.cnt[i] = s_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    trace_fifo #(.AW(AW), .DEPTH(TQ_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cmd),
        .push  (push),
        .din   (pc),
        .pop   (trace_pop),
        .valid (trace_valid),
        .dout  (trace_pc),
        .ovf   (trace_ovf),
        .level (fifo_level)
    );

    assign rd_count = s_q.cnt[rd_idx];
endmodule

// File: rtl/prof_chk.sv
module prof_chk #(
    parameter int N     = 8,
    parameter int CNT_W = 32,
    parameter int DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run,
    input logic [1:0]                  mode,
    input logic                        clr,
    input logic [N-1:0]                inc,
    input logic [N*CNT_W-1:0]          cnt_flat,
    input logic [$clog2(DEPTH):0]      level,
    input logic                        ovf
);
    assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_flat));

    assert_excl_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> $onehot0(inc));

    assert_trace_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !clr) |=> $stable(cnt_flat));

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH)+1)'(DEPTH));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_flat == '0 && level == '0 && !ovf));

    for (genvar g = 0; g < N; g++) begin : g_sat
        assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[g*CNT_W +: CNT_W] == {CNT_W{1'b1}} && !clr)
            |=> (cnt_flat[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
    end
endmodule

bind pc_range_prof prof_chk #(
    .N     (NUM_RANGES),
    .CNT_W (CNT_W),
    .DEPTH (TQ_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (s_q.run),
    .mode     (s_q.mode),
    .clr      (clr_cmd),
    .inc      (inc),
    .cnt_flat (s_q.cnt),
    .level    (fifo_level),
    .ovf      (trace_ovf)
);

// File: tb/pc_range_prof_tb_top.sv
module pc_range_prof_tb_top;
    localparam int NR = 8;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int DP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [2:0]    rd_idx = '0;
    logic [CW-1:0] rd_count;
    logic          trace_valid;
    logic [AW-1:0] trace_pc;
    logic          trace_pop = 1'b0;
    logic          trace_ovf;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] lo_m [NR];
    logic [AW-1:0] hi_m [NR];
    int            exp_cnt [NR];

    always #4 clk = ~clk;

    pc_range_prof #(.NUM_RANGES(NR), .AW(AW), .CNT_W(CW), .TQ_DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_count(rd_count),
        .trace_valid(trace_valid), .trace_pc(trace_pc),
        .trace_pop(trace_pop), .trace_ovf(trace_ovf)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // control word: bit0 run, bits[2:1] mode, bit3 clear
    function automatic logic [AW-1:0] ctl(input bit run, input logic [1:0] m, input bit c);
        return AW'({c, m, run});
    endfunction

    task automatic set_win(input int i, input logic [AW-1:0] l, input logic [AW-1:0] h);
        wr(5'(16 + 2*i), l);
        wr(5'(17 + 2*i), h);
        lo_m[i] = l; hi_m[i] = h;
    endtask

    task automatic send(input logic [AW-1:0] p);
        @(negedge clk);
        pc_valid = 1'b1; pc = p;
        @(negedge clk);
        pc_valid = 1'b0;
    endtask

    // model of the counting modes; excl = 1 credits only the first match
    task automatic model(input logic [AW-1:0] p, input bit excl);
        for (int i = 0; i < NR; i++) begin
            if (p >= lo_m[i] && p < hi_m[i]) begin
                if (exp_cnt[i] < 255) exp_cnt[i]++;
                if (excl) break;
            end
        end
    endtask

    task automatic check_counts(input string tag);
        for (int i = 0; i < NR; i++) begin
            @(negedge clk);
            rd_idx = 3'(i);
            #1;
            check(rd_count == CW'(exp_cnt[i]), tag, 32'(rd_count), 32'(exp_cnt[i]));
        end
    endtask

    task automatic pop_expect(input logic [AW-1:0] e, input string tag);
        @(negedge clk);
        check(trace_valid == 1'b1, tag, 32'(trace_valid), 32'd1);
        check(trace_pc == e, tag, trace_pc, e);
        trace_pop = 1'b1;
        @(negedge clk);
        trace_pop = 1'b0;
    endtask

    task automatic clear_all();
        wr(5'd0, ctl(1'b0, 2'b00, 1'b1));
        for (int i = 0; i < NR; i++) exp_cnt[i] = 0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < NR; i++) begin lo_m[i] = '0; hi_m[i] = '0; exp_cnt[i] = 0; end
        check_counts("R1 counters zero");
        check(trace_valid == 1'b0, "R1 trace empty", 32'(trace_valid), 0);
        check(trace_ovf == 1'b0, "R1 ovf low", 32'(trace_ovf), 0);
        send(32'h0);  // stopped after reset, window bounds zero: nothing counted
        check_counts("R1 stopped at reset");
    endtask

    logic [AW-1:0] pcs [8] = '{32'h1000, 32'h17FC, 32'h1800, 32'h2000,
                               32'h20FC, 32'h2100, 32'h5000, 32'h0FFC};

    task automatic t_overlap();
        set_win(0, 32'h1000, 32'h2000);
        set_win(1, 32'h1800, 32'h3000);
        set_win(2, 32'h2000, 32'h2100);
        set_win(3, 32'h5000, 32'h5000); // empty window (R2)
        set_win(4, 32'h6000, 32'h4000); // inverted window (R2)
        wr(5'd0, ctl(1'b1, 2'b00, 1'b0));
        foreach (pcs[k]) begin send(pcs[k]); model(pcs[k], 1'b0); end
        check_counts("R3 R2 overlap counts");
        check(trace_valid == 1'b0, "R5 nothing queued when counting", 32'(trace_valid), 0);
    endtask

    task automatic t_clear_same_edge();
        // clear write and PC in the same edge: PC not counted, run stays on
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = ctl(1'b1, 2'b00, 1'b1);
        pc_valid = 1'b1; pc = 32'h1000;
        @(negedge clk);
        cfg_we = 1'b0; pc_valid = 1'b0;
        for (int i = 0; i < NR; i++) exp_cnt[i] = 0;
        check_counts("R9 clear wins");
        send(32'h1800); model(32'h1800, 1'b0);
        check_counts("R9 run kept by clear write");
    endtask

    task automatic t_excl();
        clear_all();
        wr(5'd0, ctl(1'b1, 2'b01, 1'b0));
        foreach (pcs[k]) begin send(pcs[k]); model(pcs[k], 1'b1); end
        check_counts("R4 exclusive counts");
    endtask

    task automatic t_stop();
        wr(5'd0, ctl(1'b0, 2'b01, 1'b0));
        foreach (pcs[k]) send(pcs[k]);
        check_counts("R7 stopped counts frozen");
        wr(5'd0, ctl(1'b0, 2'b10, 1'b0));
        send(32'h1234);
        @(negedge clk);
        check(trace_valid == 1'b0, "R7 stopped no trace", 32'(trace_valid), 0);
    endtask

    task automatic t_trace();
        wr(5'd0, ctl(1'b1, 2'b10, 1'b0));
        for (int k = 0; k < 5; k++) send(32'hA000 + 32'(k*4));
        check_counts("R5 counts untouched in trace");
        for (int k = 0; k < 5; k++) pop_expect(32'hA000 + 32'(k*4), "R5 trace order");
        @(negedge clk);
        check(trace_valid == 1'b0, "R5 drained", 32'(trace_valid), 0);
    endtask

    task automatic t_overflow();
        clear_all();
        wr(5'd0, ctl(1'b1, 2'b10, 1'b0));
        for (int k = 0; k < DP; k++) send(32'hB000 + 32'(k));
        @(negedge clk);
        check(trace_ovf == 1'b0, "R6 no ovf at exactly full", 32'(trace_ovf), 0);
        send(32'hB010);
        check(trace_ovf == 1'b1, "R6 ovf on drop", 32'(trace_ovf), 1);
        @(negedge clk);
        pc_valid = 1'b1; pc = 32'hB011; trace_pop = 1'b1;
        @(negedge clk);
        pc_valid = 1'b0; trace_pop = 1'b0;
        for (int k = 1; k < DP; k++) pop_expect(32'hB000 + 32'(k), "R6 drop when full with pop");
        @(negedge clk);
        check(trace_valid == 1'b0, "R6 only 15 left", 32'(trace_valid), 0);
        check(trace_ovf == 1'b1, "R6 ovf sticky", 32'(trace_ovf), 1);
        send(32'hC000);
        clear_all();
        @(negedge clk);
        check(trace_ovf == 1'b0, "R9 clear ovf", 32'(trace_ovf), 0);
        check(trace_valid == 1'b0, "R9 clear fifo", 32'(trace_valid), 0);
    endtask

    task automatic t_saturate();
        clear_all();
        set_win(0, 32'h0, 32'h100);
        wr(5'd0, ctl(1'b1, 2'b00, 1'b0));
        for (int k = 0; k < 260; k++) begin send(32'h10); model(32'h10, 1'b0); end
        check_counts("R8 saturation");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_overlap();
        t_clear_same_edge();
        t_excl();
        t_stop();
        t_trace();
        t_overflow();
        t_saturate();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule